// File: doc/BRIEF.md
# Parallel RGB Display Timing Generator

This block drives the timing of a parallel 24-bit RGB panel from the dot clock. It runs a horizontal counter in dot clocks and a vertical counter in whole lines. From these two counters it derives the horizontal and vertical sync pulses, a data-enable signal, a pixel-request strobe and the coordinates of the current active pixel. All configuration arrives on static input ports: the totals, the sync lengths, the start offsets, the active size and the polarities.

Pixels come from an upstream source through a simple valid signal. Each cycle the block raises its request inside the active window. If the source has no pixel ready in such a cycle, that is an underflow. The block then sets a sticky flag and stops requesting for the rest of the frame, sending black while the timing runs on undisturbed. It resumes requesting at the first active pixel of the next frame, so the picture realigns to a frame boundary.

Top module: `rgb_timing_gen`

## Requirements
- R1: Releasing reset puts the position at the leading edge of both sync pulses: line 0, clock 0, with no pixel requested and the underflow flag clear.
- R2: A line lasts `cfg_h_total` clocks. Horizontal sync is asserted during the first `cfg_hs_len` clocks of each line.
- R3: A frame lasts `cfg_v_total` lines. Vertical sync is asserted during the first `cfg_vs_len` whole lines, and it changes level only at a line start.
- R4: Counted from the hsync leading edge, pixels are requested in clocks `cfg_h_start` to `cfg_h_start+cfg_h_pixels-1` of an active line, and `x_pos` runs from 0 to `cfg_h_pixels-1` across them.
- R5: Counted from the vsync leading edge, lines `cfg_v_start` to `cfg_v_start+cfg_v_lines-1` are active, and `y_pos` runs from 0 upward across them. Both coordinates read 0 outside the active window.
- R6: When `cfg_de_en` is 1, `de` sits at its asserted level exactly in active cycles. When `cfg_de_en` is 0, `de` is held at 0.
- R7: The asserted level of `hsync`, `vsync` and `de` each equals its own polarity bit: 1 means active-high and 0 means active-low.
- R8: While `cfg_sync_en` is 0, the counters stay at the line 0 / clock 0 position, both syncs sit at their inactive levels, and no pixel is requested. Enabling again starts from the sync leading edge.
- R9: `rgb_out` equals `pix_data` in a cycle where a pixel is requested and `pix_valid` is 1. Otherwise it is 0 (black).
- R10: An underflow is a requested cycle with `pix_valid` 0. It sets `ufl_flag` on the next clock and suppresses `pix_req` for the rest of that frame.
- R11: After an underflow, requests resume at the first active pixel of the next frame, and that frame requests the full `cfg_h_pixels*cfg_v_lines` pixels.
- R12: `ufl_flag` stays set until `ufl_clear` is 1 at a clock edge. If a new underflow occurs in that same cycle, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | dot clock |
| rst_n | input | 1 | active-low reset |
| cfg_sync_en | input | 1 | run the timing counters |
| cfg_de_en | input | 1 | drive the data-enable output |
| cfg_hs_pol | input | 1 | hsync asserted level |
| cfg_vs_pol | input | 1 | vsync asserted level |
| cfg_de_pol | input | 1 | de asserted level |
| cfg_h_total | input | HW | clocks per line |
| cfg_hs_len | input | HW | hsync length in clocks |
| cfg_h_start | input | HW | clocks from hsync edge to first pixel |
| cfg_h_pixels | input | HW | active pixels per line |
| cfg_v_total | input | VW | lines per frame |
| cfg_vs_len | input | VW | vsync length in lines |
| cfg_v_start | input | VW | lines from vsync edge to first active line |
| cfg_v_lines | input | VW | active lines per frame |
| pix_data | input | PW | incoming pixel |
| pix_valid | input | 1 | incoming pixel present |
| ufl_clear | input | 1 | clear the underflow flag |
| pix_req | output | 1 | pixel consumed this clock |
| rgb_out | output | PW | pixel to the panel |
| hsync | output | 1 | horizontal sync |
| vsync | output | 1 | vertical sync |
| de | output | 1 | data enable |
| x_pos | output | HW | active column |
| y_pos | output | VW | active row |
| ufl_flag | output | 1 | sticky underflow |

## Verification
The bench aims at three edges. The first is the edge of the active window, where an off-by-one in the start or size comparison would shift or widen `pix_req` by a clock or a line. The second is the vertical counter, which must advance only at the line wrap: a design that counted vsync in clocks would end its pulse after a few dots. The third is underflow recovery. There a design that resumed on the next line, or never, would show the wrong number of requests in the current and the following frame. The bench also checks what happens when clear and a new underflow land in the same cycle, and when timing is disabled in the middle of a frame and then enabled again.

// File: rtl/rgb_timing_gen.sv
module rgb_timing_gen #(
  parameter int HW = 12,
  parameter int VW = 12,
  parameter int PW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_sync_en,
  input  logic          cfg_de_en,
  input  logic          cfg_hs_pol,
  input  logic          cfg_vs_pol,
  input  logic          cfg_de_pol,
  input  logic [HW-1:0] cfg_h_total,
  input  logic [HW-1:0] cfg_hs_len,
  input  logic [HW-1:0] cfg_h_start,
  input  logic [HW-1:0] cfg_h_pixels,
  input  logic [VW-1:0] cfg_v_total,
  input  logic [VW-1:0] cfg_vs_len,
  input  logic [VW-1:0] cfg_v_start,
  input  logic [VW-1:0] cfg_v_lines,
  input  logic [PW-1:0] pix_data,
  input  logic          pix_valid,
  input  logic          ufl_clear,
  output logic          pix_req,
  output logic [PW-1:0] rgb_out,
  output logic          hsync,
  output logic          vsync,
  output logic          de,
  output logic [HW-1:0] x_pos,
  output logic [VW-1:0] y_pos,
  output logic          ufl_flag
);
  logic [HW-1:0] h_cnt;
  logic [VW-1:0] v_cnt;
  logic          skip;
  logic          ufl_q;

  wire line_end  = ({1'b0, h_cnt} + 1'b1) >= {1'b0, cfg_h_total};
  wire last_line = ({1'b0, v_cnt} + 1'b1) >= {1'b0, cfg_v_total};
  wire frame_end = line_end & last_line;

  wire h_act = (h_cnt >= cfg_h_start) &&
               ({1'b0, h_cnt} < ({1'b0, cfg_h_start} + {1'b0, cfg_h_pixels}));
  wire v_act = (v_cnt >= cfg_v_start) &&
               ({1'b0, v_cnt} < ({1'b0, cfg_v_start} + {1'b0, cfg_v_lines}));
  wire active = cfg_sync_en & h_act & v_act;

  wire hs_on = cfg_sync_en & (h_cnt < cfg_hs_len);
  wire vs_on = cfg_sync_en & (v_cnt < cfg_vs_len);
  wire ufl_evt = pix_req & ~pix_valid;

  assign pix_req  = active & ~skip;
  assign rgb_out  = (pix_req & pix_valid) ? pix_data : '0;
  assign hsync    = hs_on ? cfg_hs_pol : ~cfg_hs_pol;
  assign vsync    = vs_on ? cfg_vs_pol : ~cfg_vs_pol;
  assign de       = cfg_de_en & (active ? cfg_de_pol : ~cfg_de_pol);
  assign x_pos    = active ? h_cnt - cfg_h_start : '0;
  assign y_pos    = active ? v_cnt - cfg_v_start : '0;
  assign ufl_flag = ufl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h_cnt <= '0;
      v_cnt <= '0;
      skip  <= 1'b0;
    end else if (!cfg_sync_en) begin
      h_cnt <= '0;
      v_cnt <= '0;
      skip  <= 1'b0;
    end else begin
      h_cnt <= line_end ? '0 : h_cnt + 1'b1;
      if (line_end) v_cnt <= last_line ? '0 : v_cnt + 1'b1;
      if (frame_end)    skip <= 1'b0;
      else if (ufl_evt) skip <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         ufl_q <= 1'b0;
    else if (ufl_evt)   ufl_q <= 1'b1;
    else if (ufl_clear) ufl_q <= 1'b0;
  end
endmodule

module rgb_timing_gen_chk #(
  parameter int HW = 12,
  parameter int VW = 12,
  parameter int PW = 24
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_sync_en,
  input logic          cfg_de_en,
  input logic          cfg_hs_pol,
  input logic          cfg_vs_pol,
  input logic          cfg_de_pol,
  input logic [HW-1:0] cfg_hs_len,
  input logic [VW-1:0] cfg_vs_len,
  input logic          pix_valid,
  input logic          ufl_clear,
  input logic          pix_req,
  input logic [PW-1:0] rgb_out,
  input logic          hsync,
  input logic          vsync,
  input logic          de,
  input logic [HW-1:0] x_pos,
  input logic          ufl_flag
);
  AST_IDLE_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_sync_en |-> (!pix_req && hsync == !cfg_hs_pol && vsync == !cfg_vs_pol && x_pos == '0)); // R8
  AST_DE_HELD_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_de_en |-> !de); // R6
  AST_REQ_UNDER_DE: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_de_en && pix_req) |-> de == cfg_de_pol); // R6
  AST_BLACK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_req |-> rgb_out == '0); // R9
  AST_UFL_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_req && !pix_valid) |=> ufl_flag); // R10
  AST_UFL_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (ufl_clear && !(pix_req && !pix_valid)) |=> !ufl_flag); // R12
  AST_VS_AT_LINE_START: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && cfg_sync_en && $past(cfg_sync_en) && $stable(cfg_vs_pol) &&
     $stable(cfg_vs_len) && cfg_hs_len != '0 && vsync != $past(vsync))
    |-> hsync == cfg_hs_pol); // R3
endmodule

bind rgb_timing_gen rgb_timing_gen_chk #(.HW(HW), .VW(VW), .PW(PW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_sync_en(cfg_sync_en), .cfg_de_en(cfg_de_en),
  .cfg_hs_pol(cfg_hs_pol), .cfg_vs_pol(cfg_vs_pol), .cfg_de_pol(cfg_de_pol),
  .cfg_hs_len(cfg_hs_len), .cfg_vs_len(cfg_vs_len), .pix_valid(pix_valid),
  .ufl_clear(ufl_clear), .pix_req(pix_req), .rgb_out(rgb_out), .hsync(hsync),
  .vsync(vsync), .de(de), .x_pos(x_pos), .ufl_flag(ufl_flag)
);

// File: tb/rgb_timing_gen_bench.sv
module rgb_timing_gen_bench;
  localparam int HP = 20, HSL = 3, HST = 5, HPX = 8;
  localparam int VP = 12, VSL = 2, VST = 3, VLN = 5;
  localparam int FRAME = HP * VP;

  logic clk = 0;
  logic rst_n = 0;
  logic sync_en = 0, de_en = 1, hs_pol = 0, vs_pol = 0, de_pol = 1;
  logic [23:0] pix_data = 0;
  logic pix_valid = 1, ufl_clear = 0;
  logic pix_req, hsync, vsync, de, ufl_flag;
  logic [23:0] rgb_out;
  logic [11:0] x_pos, y_pos;

  int total = 0, bad = 0;
  int mh = 0, mv = 0;
  bit mskip = 0, mflag = 0;

  always #4 clk = ~clk;

  rgb_timing_gen u_rgb_timing_gen (
    .clk(clk), .rst_n(rst_n), .cfg_sync_en(sync_en), .cfg_de_en(de_en),
    .cfg_hs_pol(hs_pol), .cfg_vs_pol(vs_pol), .cfg_de_pol(de_pol),
    .cfg_h_total(12'(HP)), .cfg_hs_len(12'(HSL)), .cfg_h_start(12'(HST)),
    .cfg_h_pixels(12'(HPX)), .cfg_v_total(12'(VP)), .cfg_vs_len(12'(VSL)),
    .cfg_v_start(12'(VST)), .cfg_v_lines(12'(VLN)), .pix_data(pix_data),
    .pix_valid(pix_valid), .ufl_clear(ufl_clear), .pix_req(pix_req),
    .rgb_out(rgb_out), .hsync(hsync), .vsync(vsync), .de(de),
    .x_pos(x_pos), .y_pos(y_pos), .ufl_flag(ufl_flag)
  );

  function automatic bit m_act();
    return sync_en && mh >= HST && mh < HST + HPX && mv >= VST && mv < VST + VLN;
  endfunction

  // reference position model, built from the requirements
  always @(posedge clk) begin
    bit evt;
    evt = m_act() && !mskip && !pix_valid;
    if (!rst_n) begin
      mh = 0; mv = 0; mskip = 0; mflag = 0;
    end else begin
      if (evt) mflag = 1; else if (ufl_clear) mflag = 0;
      if (!sync_en) begin
        mh = 0; mv = 0; mskip = 0;
      end else begin
        if (mh == HP-1 && mv == VP-1) mskip = 0; else if (evt) mskip = 1;
        if (mh == HP-1) begin mh = 0; mv = (mv == VP-1) ? 0 : mv + 1; end
        else mh = mh + 1;
      end
    end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare(input string tag);
    bit a, req;
    a = m_act();
    req = a && !mskip;
    check(hsync == ((sync_en && mh < HSL) ? hs_pol : !hs_pol), {tag, " R2 R7 hsync"}, hsync, (sync_en && mh < HSL) ? hs_pol : !hs_pol);
    check(vsync == ((sync_en && mv < VSL) ? vs_pol : !vs_pol), {tag, " R3 R7 vsync"}, vsync, (sync_en && mv < VSL) ? vs_pol : !vs_pol);
    check(de == (de_en && (a ? de_pol : !de_pol)), {tag, " R6 de"}, de, de_en && (a ? de_pol : !de_pol));
    check(pix_req == req, {tag, " R4 R10 pix_req"}, pix_req, req);
    check(x_pos == (a ? 12'(mh - HST) : 12'd0), {tag, " R4 x_pos"}, x_pos, a ? mh - HST : 0);
    check(y_pos == (a ? 12'(mv - VST) : 12'd0), {tag, " R5 y_pos"}, y_pos, a ? mv - VST : 0);
    check(rgb_out == ((req && pix_valid) ? pix_data : 24'd0), {tag, " R9 rgb_out"}, rgb_out, (req && pix_valid) ? pix_data : 0);
    check(ufl_flag == mflag, {tag, " R12 ufl_flag"}, ufl_flag, mflag);
  endtask

  task automatic run(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      pix_data = 24'hC00000 | 24'(i * 7 + 3);
      #1 compare(tag);
    end
  endtask

  // count requests over one whole frame starting at the next frame start
  task automatic count_frame(output int n);
    n = 0;
    for (int i = 0; i < FRAME; i++) begin
      @(negedge clk); #1;
      if (pix_req) n++;
    end
  endtask

  task automatic wait_frame_start();
    do begin @(negedge clk); #1 compare("sync"); end while (!(mh == HP-1 && mv == VP-1));
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    #1;
    check(!pix_req, "R1 reset pix_req", pix_req, 0);
    check(!ufl_flag, "R1 reset ufl_flag", ufl_flag, 0);
    check(hsync == 1'b1, "R8 reset hsync idle", hsync, 1);
    check(rgb_out == 0, "R9 reset rgb_out", rgb_out, 0);
    sync_en = 1;
    #1;
    check(hsync == 1'b0, "R1 hsync at leading edge", hsync, 0);
    check(vsync == 1'b0, "R1 vsync at leading edge", vsync, 0);
    rst_n = 1;
  endtask

  task automatic t_basic();
    int n;
    run(2 * FRAME, "basic");
    wait_frame_start();
    count_frame(n);
    check(n == HPX * VLN, "R4 R5 requests per frame", n, HPX * VLN);
  endtask

  task automatic t_polarity();
    @(negedge clk);
    hs_pol = 1; vs_pol = 1; de_pol = 0; de_en = 0;
    run(FRAME, "pol_de_off");
    @(negedge clk);
    de_en = 1;
    run(FRAME, "pol_inverted");
    @(negedge clk);
    hs_pol = 0; vs_pol = 0; de_pol = 1;
    run(FRAME / 2, "pol_restored");
  endtask

  task automatic t_sync_off();
    run(FRAME / 2 + 7, "pre_off");
    @(negedge clk);
    sync_en = 0;
    run(30, "R8 off");
    @(negedge clk);
    sync_en = 1;
    #1;
    check(hsync == hs_pol && vsync == vs_pol, "R8 restart at sync edge", {hsync, vsync}, {hs_pol, vs_pol});
    run(FRAME + 10, "R8 restart");
  endtask

  task automatic t_underflow();
    int n;
    do begin @(negedge clk); #1 compare("seek"); end while (!(m_act() && !mskip && mv == VST + 1 && mh == HST + 2));
    pix_valid = 0;
    @(negedge clk);
    pix_valid = 1;
    #1 compare("R10 after ufl");
    check(ufl_flag, "R10 flag set", ufl_flag, 1);
    n = 0;
    while (!(mh == HP-1 && mv == VP-1)) begin
      @(negedge clk); #1 compare("R10 skipping");
      if (pix_req) n++;
    end
    check(n == 0, "R10 no requests rest of frame", n, 0);
    count_frame(n);
    check(n == HPX * VLN, "R11 full frame after recovery", n, HPX * VLN);
    check(ufl_flag, "R12 flag sticky", ufl_flag, 1);
    @(negedge clk);
    ufl_clear = 1;
    @(negedge clk);
    ufl_clear = 0;
    #1;
    check(!ufl_flag, "R12 flag cleared", ufl_flag, 0);
    do begin @(negedge clk); #1 compare("seek2"); end while (!(m_act() && !mskip));
    pix_valid = 0; ufl_clear = 1;
    @(negedge clk);
    pix_valid = 1; ufl_clear = 0;
    #1;
    check(ufl_flag, "R12 set wins over clear", ufl_flag, 1);
    run(FRAME + 5, "R11 tail");
  endtask

  initial begin
    t_reset();
    t_basic();
    t_polarity();
    t_sync_off();
    t_underflow();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(8 * 200000);
    total++; bad++;
    $display("FAIL watchdog R1 actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule